// File: doc/BRIEF.md
# Multi-Source Initial Reset Controller

This block produces the single chip-wide initial reset of a small 4-bit microcontroller. It merges four reset causes: an active-low external reset pin, an oscillator-good flag that stays low until the crystal oscillator has started, a one-cycle timeout pulse from the watchdog, and a key-combination reset. The key-combination reset fires when a configured group of the four input-port lines is held low together for a long, qualified time, which is about two seconds at the 32.768 kHz clock.

The port lines and the reset pin are brought into the clock domain through two-stage synchronizers. A hold counter then measures how long the selected lines stay low. The output is registered and asserts as soon as any cause is active. When the last cause goes away, the output is released on a clock edge after a fixed stretch.

Top module: `init_reset_ctrl`

## Requirements
- R1: While `osc_good` is low, `init_rst` is high from the next clock edge on; the oscillator-bad state also clears the hold counter.
- R2: A `wdt_bite` pulse lasting L cycles makes `init_rst` rise at the first clock edge and stay high for L+STRETCH_CYCLES cycles.
- R3: `ext_rst_n` passes through two synchronizer flops. Holding it low for L cycles makes `init_rst` rise at the third clock edge and stay high for L+STRETCH_CYCLES cycles.
- R4: `combo_sel` picks the key group: 00 disables the key reset, 01 selects K0,K1, 10 selects K0..K2, and 11 selects K0..K3 (`port_k_n[i]` is line Ki). The key reset is armed only when every selected line is low in the same cycle; the levels of unselected lines have no effect.
- R5: Once the selected lines are low, the key reset asserts only after HOLD_CYCLES consecutive synchronized low cycles. With the lines low for N cycles and N > HOLD_CYCLES, `init_rst` rises at edge HOLD_CYCLES+3. With N ≤ HOLD_CYCLES, no reset occurs.
- R6: If any selected line goes high before the hold completes, the hold count returns to zero, so two partial holds never add up.
- R7: After qualification, the key reset stays active for as long as the selected lines stay low, so the output lasts N-HOLD_CYCLES+STRETCH_CYCLES cycles.
- R8: `init_rst` is the registered OR of all causes. It falls on the clock edge STRETCH_CYCLES cycles after the registered image of the last active cause ends, and overlapping causes merge into a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz system clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| port_k_n | input | 4 | Input-port lines K0..K3, low means held |
| combo_sel | input | 2 | Static key-group select code |
| osc_good | input | 1 | High once the crystal oscillator runs |
| wdt_bite | input | 1 | Watchdog timeout pulse, synchronous |
| init_rst | output | 1 | Chip-wide initial reset, active high |

## Verification
The bench sweeps all 64 pairs of select code and port pattern. This catches a wrong mask, an inverted key polarity, or unselected lines being wrongly taken into account. It holds the keys for exactly HOLD_CYCLES and for HOLD_CYCLES+1 cycles, where an off-by-one counter would either fire early or never fire. It interrupts a hold with a one-cycle release. A counter that paused instead of clearing would then fire on the combined time. It also measures the rise latency and the pulse length for each cause alone and for overlapping causes, so a missing synchronizer stage, a short stretch or a gap between merged pulses shows up as a wrong number of cycles.

// File: rtl/init_rst_pkg.sv
package init_rst_pkg;

    localparam int unsigned NUM_KEYS = 4;

    typedef enum logic [1:0] {
        COMBO_OFF   = 2'b00,
        COMBO_K01   = 2'b01,
        COMBO_K012  = 2'b10,
        COMBO_K0123 = 2'b11
    } combo_e;

    typedef struct packed {
        logic pin;
        logic key;
        logic wdt;
        logic osc;
    } cause_t;

    function automatic logic [NUM_KEYS-1:0] combo_mask(input combo_e c);
        case (c)
            COMBO_K01:   combo_mask = 4'b0011;
            COMBO_K012:  combo_mask = 4'b0111;
            COMBO_K0123: combo_mask = 4'b1111;
            default:     combo_mask = 4'b0000;
        endcase
    endfunction

    function automatic logic any_cause(input cause_t c);
        any_cause = c.pin | c.key | c.wdt | c.osc;
    endfunction

endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= IDLE;
            q      <= IDLE;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irc_key_qual.sv
module irc_key_qual
    import init_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 65536
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] keys_n_s,
    input  combo_e              sel,
    output logic                key_active
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    logic [NUM_KEYS-1:0] mask;
    logic                all_low;
    logic [CW-1:0]       hold_cnt;
    logic                done;

    assign mask    = combo_mask(sel);
    assign all_low = (mask != '0) && ((keys_n_s & mask) == '0);
    assign done    = (hold_cnt == CW'(HOLD_CYCLES));

    always_ff @(posedge clk) begin
        if (rst || !all_low) begin
            hold_cnt <= '0;
        end else if (!done) begin
            hold_cnt <= hold_cnt + CW'(1);
        end
    end

    assign key_active = all_low && done;

    // R6
    counter_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !all_low |=> (hold_cnt == '0));

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == COMBO_OFF) |-> !key_active);

    // R5
    qualified_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(key_active) |-> $past(all_low));
endmodule

// File: rtl/irc_stretch.sv
module irc_stretch
    import init_rst_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 4
) (
    input  logic   clk,
    input  cause_t causes,
    output logic   rst_out
);
    localparam int unsigned SW = $clog2(STRETCH_CYCLES + 1);

    logic          any;
    logic [SW-1:0] tail_cnt;

    assign any = any_cause(causes);

    always_ff @(posedge clk) begin
        if (any) begin
            rst_out  <= 1'b1;
            tail_cnt <= '0;
        end else if (rst_out) begin
            if (tail_cnt == SW'(STRETCH_CYCLES)) begin
                rst_out <= 1'b0;
            end else begin
                tail_cnt <= tail_cnt + SW'(1);
            end
        end
    end

    // R8
    any_sets_chk: assert property (@(posedge clk) disable iff (causes.osc)
        any |=> rst_out);

    generate
        if (STRETCH_CYCLES >= 4) begin : g_tail_chk
            // R8
            release_quiet_chk: assert property (@(posedge clk) disable iff (causes.osc)
                $fell(rst_out) |-> (!$past(any, 1) && !$past(any, 2) &&
                                    !$past(any, 3) && !$past(any, 4)));
        end
    endgenerate
endmodule

// File: rtl/init_reset_ctrl.sv
module init_reset_ctrl
    import init_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES    = 65536,
    parameter int unsigned STRETCH_CYCLES = 4
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic [3:0] port_k_n,
    input  logic [1:0] combo_sel,
    input  logic       osc_good,
    input  logic       wdt_bite,
    output logic       init_rst
);
    logic                rst;
    logic                pin_s;
    logic [NUM_KEYS-1:0] keys_s;
    logic                key_active;
    cause_t              causes;

    assign rst = !osc_good;

    irc_sync #(.W(1), .IDLE(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_rst_n),
        .q   (pin_s)
    );

    irc_sync #(.W(NUM_KEYS), .IDLE({NUM_KEYS{1'b1}})) u_key_sync (
        .clk (clk),
        .rst (rst),
        .d   (port_k_n),
        .q   (keys_s)
    );

    irc_key_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .keys_n_s   (keys_s),
        .sel        (combo_e'(combo_sel)),
        .key_active (key_active)
    );

    always_comb begin
        causes.pin = !pin_s;
        causes.key = key_active;
        causes.wdt = wdt_bite;
        causes.osc = rst;
    end

    irc_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
        .clk     (clk),
        .causes  (causes),
        .rst_out (init_rst)
    );

    // R1
    osc_holds_chk: assert property (@(posedge clk)
        !osc_good |=> init_rst);

    // R2
    wdt_forces_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_bite |=> init_rst);

    // R3
    pin_forces_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_s |=> init_rst);
endmodule

// File: tb/init_reset_ctrl_test.sv
`timescale 1ns/1ps
module init_reset_ctrl_test;
    localparam int HOLD = 20;
    localparam int STR  = 4;

    logic       clk = 1'b0;
    logic       ext_rst_n;
    logic [3:0] port_k_n;
    logic [1:0] combo_sel;
    logic       osc_good;
    logic       wdt_bite;
    logic       init_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    init_reset_ctrl #(.HOLD_CYCLES(HOLD), .STRETCH_CYCLES(STR)) uut (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .port_k_n  (port_k_n),
        .combo_sel (combo_sel),
        .osc_good  (osc_good),
        .wdt_bite  (wdt_bite),
        .init_rst  (init_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One stimulus window; sample i reflects clock edge i+1 after start.
    task automatic run(input logic [1:0] sel, input logic [3:0] pat,
                       input int key_len, input int gap, input int ext_len,
                       input int wdt_len, input int total,
                       output int lat, output int len);
        lat = 0;
        len = 0;
        combo_sel = sel;
        for (int i = 0; i < total; i++) begin
            port_k_n  = (i < key_len && i != gap) ? pat : 4'hF;
            ext_rst_n = (i < ext_len) ? 1'b0 : 1'b1;
            wdt_bite  = (i < wdt_len);
            @(negedge clk);
            if (init_rst) begin
                len++;
                if (lat == 0) lat = i + 1;
            end
        end
        port_k_n  = 4'hF;
        ext_rst_n = 1'b1;
        wdt_bite  = 1'b0;
    endtask

    function automatic logic [3:0] mask_of(input logic [1:0] s);
        return (s == 2'd0) ? 4'h0 : ((4'h1 << (s + 1)) - 4'h1);
    endfunction

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat, len, n;
        logic q;
        ext_rst_n = 1'b1;
        port_k_n  = 4'hF;
        combo_sel = 2'd0;
        wdt_bite  = 1'b0;
        osc_good  = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 reset held while oscillator bad", int'(init_rst), 1);

        // R1/R8: release of oscillator-bad, 4 stretch cycles then low
        osc_good = 1'b1;
        run(2'd0, 4'hF, 0, -1, 0, 0, 10, lat, len);
        chk("R8 stretch after oscillator release", len, STR);
        chk("R8 output low when idle", int'(init_rst), 0);

        // R2 watchdog
        run(2'd0, 4'hF, 0, -1, 0, 1, 12, lat, len);
        chk("R2 wdt latency", lat, 1);
        chk("R2 wdt length L=1", len, 1 + STR);
        run(2'd0, 4'hF, 0, -1, 0, 3, 12, lat, len);
        chk("R2 wdt length L=3", len, 3 + STR);

        // R3 external pin
        run(2'd0, 4'hF, 0, -1, 1, 0, 14, lat, len);
        chk("R3 pin latency", lat, 3);
        chk("R3 pin length L=1", len, 1 + STR);
        run(2'd0, 4'hF, 0, -1, 6, 0, 18, lat, len);
        chk("R3 pin length L=6", len, 6 + STR);

        // R8 overlapping causes merge into one pulse
        run(2'd0, 4'hF, 0, -1, 1, 1, 14, lat, len);
        chk("R8 merged latency", lat, 1);
        chk("R8 merged length", len, 3 + STR);

        // R4 exhaustive select x pattern sweep, N = HOLD+3
        n = HOLD + 3;
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 16; p++) begin
                q = (mask_of(2'(s)) != 4'h0) && ((4'(p) & mask_of(2'(s))) == 4'h0);
                run(2'(s), 4'(p), n, -1, 0, 0, n + 12, lat, len);
                chk($sformatf("R4 sel=%0d pat=%0h latency", s, p), lat, q ? HOLD + 3 : 0);
                chk($sformatf("R4 sel=%0d pat=%0h length", s, p), len, q ? n - HOLD + STR : 0);
            end
        end

        // R5 hold boundaries
        run(2'd3, 4'h0, HOLD, -1, 0, 0, HOLD + 12, lat, len);
        chk("R5 hold exactly HOLD no reset", len, 0);
        run(2'd3, 4'h0, HOLD + 1, -1, 0, 0, HOLD + 14, lat, len);
        chk("R5 hold HOLD+1 latency", lat, HOLD + 3);
        chk("R5 hold HOLD+1 length", len, 1 + STR);

        // R6 interrupted hold does not accumulate
        run(2'd2, 4'h8, 2 * HOLD - 3, HOLD - 2, 0, 0, 2 * HOLD + 10, lat, len);
        chk("R6 interrupted hold no reset", len, 0);

        // R7 long hold keeps reset asserted
        run(2'd1, 4'hC, HOLD + 30, -1, 0, 0, HOLD + 42, lat, len);
        chk("R7 long hold length", len, 30 + STR);

        // R1 oscillator drop mid-run
        osc_good = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 oscillator drop asserts reset", int'(init_rst), 1);
        osc_good = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 release after oscillator recovers", int'(init_rst), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule